// File: doc/BRIEF.md
# UART Transmitter with Holding Register

This block serialises host data onto an asynchronous transmit line. The host writes a word into a one-entry holding register. A separate shift register takes the word from there and sends it as a non-return-to-zero frame: a low start bit, then 8 or 9 data bits with the least significant first, then a high stop bit. Bit timing comes from `bit_tick`, a one-cycle strobe produced by an external baud generator. Each tick ends the current bit. The ninth data bit is whatever the host writes in `wr_data[8]`, and the block gives it no meaning of its own.

The holding register is refilled only after the shift register has taken its previous word. The shift register takes a word only when it is idle or at the tick that ends a stop bit, so consecutive frames follow each other with no idle gap. `hold_empty` tells the host when it may write again. It can be used as an interrupt request. The host cannot clear it, and it lags the register by one extra cycle. `shift_empty` is a status bit that shows whether a frame is in progress. It drives no interrupt.

A finite state machine in the shifter has four states:
- **IDLE**: the line is high. Goes to START (and takes the word) on a tick while the holding register is full.
- **START**: drives 0. Goes to DATA on a tick.
- **DATA**: drives `shift[0]` and shifts on each tick. Goes to STOP on the tick that ends the last data bit.
- **STOP**: drives 1. On a tick it goes to START (taking the word) if the holding register is full, otherwise to IDLE.

Dropping `tx_en` forces IDLE from any state.

Top module: `uart_tx_hold`

## Requirements
- R1: A frame is a start bit of 0, then the data bits with `wr_data[0]` first, then a stop bit of 1. The frame carries 9 data bits when `nine_bit` is 1 at the moment the word is taken, and 8 otherwise. In 8-bit frames `wr_data[8]` is never sent.
- R2: `tx_line` changes only at clock edges where `bit_tick` is sampled high. A word is taken only on such an edge, so every bit, including the start bit, lasts exactly one tick interval.
- R3: The shift register takes a word from the holding register only when it is idle or at the tick that ends a stop bit. If a word is waiting at the end of a stop bit, the next start bit follows with no idle gap.
- R4: The transfer happens in a single edge and empties the holding register. `hold_empty` reads 0 in the cycle after the transfer edge and 1 from the cycle after that.
- R5: After a write sampled at edge E, `hold_empty` still shows its old value after E. It reads 0 after edge E+1.
- R6: `hold_empty` has no clear input. It stays 1 for as long as the holding register is empty and transmit is enabled.
- R7: `shift_empty` is 1 exactly when no frame is in progress. While it is 1, `tx_line` is 1.
- R8: `hold_empty` becomes 1 one edge after `tx_en` is sampled high. While `tx_en` is low, `hold_empty` reads 0 and writes are ignored.
- R9: The line idles high. If `tx_en` drops during a frame, the line and `shift_empty` are high after the next edge, and both the frame and any waiting word are discarded.
- R10: The frame length is fixed when the word is taken. A change of `nine_bit` during a frame does not affect that frame.
- R11: A write while the holding register is full replaces the waiting word, so the last write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| bit_tick | input | 1 | One-cycle bit-rate strobe |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Word to send (bit 8 is the optional ninth bit) |
| tx_line | output | 1 | Serial output |
| hold_empty | output | 1 | Holding register empty flag (interrupt source) |
| shift_empty | output | 1 | Shift register idle status |

## Verification
Each result has a fixed latency, and the bench samples at that point:
- **Line:** `tx_line` moves one edge after a sampled tick. The bench finds the first negative edge at which the start bit is low. It then compares every negative edge of every bit over exactly one tick interval, so a bit that is short or long by one cycle is caught.
- **Holding-empty flag:** `hold_empty` is due two edges after a write or a transfer. The bench reads it at the negative edge after the first edge, expecting the stale value, and again after the second edge, expecting the new one. During this test ticks are stopped, so no transfer can overlap.
- **Disable:** the effects of dropping `tx_en` are due one edge later, and the bench reads them at the next negative edge.

// File: rtl/uart_txh_pkg.sv
package uart_txh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } txh_state_e;
endpackage

// File: rtl/txh_hold.sv
module txh_hold #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              take_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o,
    output logic              empty_flag_o
);
    logic              full_q;
    logic [DATA_W-1:0] data_q;
    logic              flag_q;

    // The flag is one register behind the occupancy bit, which gives the two-edge latency.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
            flag_q <= 1'b0;
        end else begin
            flag_q <= enable_i && !full_q;
            if (!enable_i) begin
                full_q <= 1'b0;
            end else if (wr_i) begin
                full_q <= 1'b1;
                data_q <= wdata_i;
            end else if (take_i) begin
                full_q <= 1'b0;
            end
        end
    end

    assign full_o       = full_q;
    assign data_o       = data_q;
    assign empty_flag_o = flag_q;
endmodule

// File: rtl/txh_shifter.sv
module txh_shifter
    import uart_txh_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              tick_i,
    input  logic              nine_i,
    input  logic              hold_full_i,
    input  logic [DATA_W-1:0] hold_data_i,
    output logic              take_o,
    output logic              line_o,
    output logic              idle_o
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

    txh_state_e        st_q, st_nxt;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_q;
    logic              take;

    // Next-state and transfer decision.
    always_comb begin
        st_nxt = st_q;
        take   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (tick_i && hold_full_i) begin
                    take   = 1'b1;
                    st_nxt = ST_START;
                end
            end
            ST_START: begin
                if (tick_i) st_nxt = ST_DATA;
            end
            ST_DATA: begin
                if (tick_i && (cnt_q == last_q)) st_nxt = ST_STOP;
            end
            ST_STOP: begin
                if (tick_i) begin
                    if (hold_full_i) begin
                        take   = 1'b1;
                        st_nxt = ST_START;
                    end else begin
                        st_nxt = ST_IDLE;
                    end
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
        if (!enable_i) begin
            st_nxt = ST_IDLE;
            take   = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // Shift register, bit counter and the frame length latched at the transfer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            last_q  <= LAST_SHORT;
        end else if (take) begin
            shreg_q <= hold_data_i;
            cnt_q   <= '0;
            last_q  <= nine_i ? LAST_LONG : LAST_SHORT;
        end else if (enable_i && tick_i && (st_q == ST_DATA)) begin
            shreg_q <= {1'b0, shreg_q[DATA_W-1:1]};
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        line_o = 1'b1;
        unique case (st_q)
            ST_START: line_o = 1'b0;
            ST_DATA:  line_o = shreg_q[0];
            default:  line_o = 1'b1;
        endcase
        idle_o = (st_q == ST_IDLE);
        take_o = take;
    end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              nine_bit,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_line,
    output logic              hold_empty,
    output logic              shift_empty
);
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;

    txh_hold #(.DATA_W(DATA_W)) i_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (tx_en),
        .wr_i         (wr_en),
        .wdata_i      (wr_data),
        .take_i       (take),
        .full_o       (hold_full),
        .data_o       (hold_data),
        .empty_flag_o (hold_empty)
    );

    txh_shifter #(.DATA_W(DATA_W)) i_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (tx_en),
        .tick_i      (bit_tick),
        .nine_i      (nine_bit),
        .hold_full_i (hold_full),
        .hold_data_i (hold_data),
        .take_o      (take),
        .line_o      (tx_line),
        .idle_o      (shift_empty)
    );
endmodule

// File: rtl/txh_checker.sv
module txh_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic bit_tick,
    input logic wr_en,
    input logic tx_line,
    input logic hold_empty,
    input logic shift_empty
);
    assert_line_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (tx_line && shift_empty));

    assert_flag_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !hold_empty);

    assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !bit_tick) |=> $stable(tx_line));

    assert_flag_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && wr_en) ##1 tx_en |=> !hold_empty);

    assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> tx_line);
endmodule

bind uart_tx_hold txh_checker i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .bit_tick    (bit_tick),
    .wr_en       (wr_en),
    .tx_line     (tx_line),
    .hold_empty  (hold_empty),
    .shift_empty (shift_empty)
);

// File: tb/test_uart_tx_hold.sv
module test_uart_tx_hold;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 6;
    // {nine_bit, wr_data[8:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        10'b0_0_1010_0101,
        10'b0_0_1111_1111,
        10'b0_0_0000_0000,
        10'b1_1_0011_1100,
        10'b1_0_1100_0011,
        10'b0_1_0101_0101
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       nine_bit = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       tx_line, hold_empty, shift_empty;
    logic       tick_on = 1'b0;
    int         tick_cnt = 0;
    int         errors = 0;
    int         checks = 0;

    uart_tx_hold #(.DATA_W(9)) i_uart_tx_hold (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .nine_bit(nine_bit),
        .bit_tick(bit_tick), .wr_en(wr_en), .wr_data(wr_data),
        .tx_line(tx_line), .hold_empty(hold_empty), .shift_empty(shift_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (tick_on) begin
            bit_tick <= (tick_cnt == TICK_DIV - 1);
            tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
        end else begin
            bit_tick <= 1'b0;
            tick_cnt <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negative edge; the write is taken at the next positive edge.
    task automatic write_word(input logic [8:0] d);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic exp_bit(input int idx, input logic nine, input logic [8:0] d);
        int n = nine ? 9 : 8;
        if (idx == 0) return 1'b0;
        if (idx <= n) return d[idx-1];
        return 1'b1;
    endfunction

    // Compares every negative edge of a frame. With immediate set, the current negedge must already be start.
    task automatic check_frame(input logic nine, input logic [8:0] d, input bit immediate, input string req);
        int n = nine ? 9 : 8;
        int bad = 0;
        int waited = 0;
        if (!immediate) begin
            while (tx_line !== 1'b0 && waited < 400) begin
                @(negedge clk);
                waited++;
            end
        end
        for (int b = 0; b < n + 2; b++) begin
            for (int p = 0; p < TICK_DIV; p++) begin
                if (tx_line !== exp_bit(b, nine, d)) bad++;
                @(negedge clk);
            end
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic wait_busy();
        int w = 0;
        while (shift_empty !== 1'b0 && w < 400) begin
            @(negedge clk);
            w++;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int highs;
        repeat (3) @(negedge clk);
        // Reset state
        chk(tx_line === 1'b1, "R9 reset line", tx_line, 1);
        chk(shift_empty === 1'b1, "R7 reset shift_empty", shift_empty, 1);
        chk(hold_empty === 1'b0, "R8 reset hold_empty", hold_empty, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: a write while disabled is ignored
        write_word(9'h0AA);
        tx_en = 1'b1;
        @(negedge clk);
        chk(hold_empty === 1'b1, "R8 flag after enable", hold_empty, 1);

        // R6: flag persists with no clear
        repeat (30) @(negedge clk);
        chk(hold_empty === 1'b1, "R6 flag held", hold_empty, 1);

        // R5: latency with ticks stopped
        wr_data = 9'h033;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        chk(hold_empty === 1'b1, "R5 stale after first edge", hold_empty, 1);
        @(negedge clk);
        chk(hold_empty === 1'b0, "R5 low after second edge", hold_empty, 0);

        // R2: no tick means no transfer
        repeat (20) @(negedge clk);
        chk(shift_empty === 1'b1 && tx_line === 1'b1, "R2 no tick no frame", shift_empty, 1);

        // R11: overwrite, then R1/R2 frame of the last word
        write_word(9'h0C5);
        tick_on = 1'b1;
        check_frame(1'b0, 9'h0C5, 1'b0, "R11 last write wins");
        chk(hold_empty === 1'b1 && shift_empty === 1'b1, "R7 idle after frame", shift_empty, 1);

        // Vector table: R1 frame formats
        for (int v = 0; v < NVEC; v++) begin
            nine_bit = VEC[v][9];
            write_word(VEC[v][8:0]);
            check_frame(VEC[v][9], VEC[v][8:0], 1'b0, $sformatf("R1 vector %0d", v));
        end

        // R3/R4: back-to-back frames
        nine_bit = 1'b0;
        write_word(9'h096);
        fork
            check_frame(1'b0, 9'h096, 1'b0, "R3 first frame");
            begin
                wait_busy();
                chk(hold_empty === 1'b0, "R4 flag right after transfer", hold_empty, 0);
                @(negedge clk);
                chk(hold_empty === 1'b1, "R4 flag set after transfer", hold_empty, 1);
                write_word(9'h069);
            end
        join
        check_frame(1'b0, 9'h069, 1'b1, "R3 no gap second frame");

        // R10: mode latched at transfer
        nine_bit = 1'b1;
        write_word(9'h0F0);
        fork
            check_frame(1'b1, 9'h0F0, 1'b0, "R10 mode latched");
            begin
                wait_busy();
                repeat (3) @(negedge clk);
                nine_bit = 1'b0;
            end
        join

        // R9: disable mid-frame drops frame and waiting word
        write_word(9'h0A3);
        wait_busy();
        repeat (10) @(negedge clk);
        write_word(9'h05C);
        tx_en = 1'b0;
        @(negedge clk);
        chk(tx_line === 1'b1, "R9 line high after disable", tx_line, 1);
        chk(shift_empty === 1'b1, "R9 shift idle after disable", shift_empty, 1);
        chk(hold_empty === 1'b0, "R8 flag low while disabled", hold_empty, 0);
        tx_en = 1'b1;
        highs = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (tx_line === 1'b1 && shift_empty === 1'b1) highs++;
        end
        chk(highs == 80, "R9 waiting word discarded", highs, 80);
        chk(hold_empty === 1'b1, "R8 flag after re-enable", hold_empty, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule